// File: doc/BRIEF.md
# Multi-Mode Sample FIFO Controller

This block buffers three-axis motion samples (three signed axis words packed into one entry) in a 32-entry buffer. A small control register selects how the buffer fills. Bypass stores nothing. FIFO mode stops accepting once the buffer is full. Stream mode keeps the newest entries and discards the oldest. Trigger mode keeps a sliding window of recent samples until an interrupt source fires, and then fills up to full. A consumer drains the buffer through a pop port and reads the entry count.

The same register holds a sample threshold. In FIFO and stream modes a watermark flag rises once the stored count reaches this threshold. In trigger mode the threshold is the size of the pre-trigger window. A threshold of zero raises the watermark flag at once in every mode. Two interrupt lines come in, and a select bit picks the one that arms the trigger. The trigger event is latched and reported until the register is written again.

Top module: `sample_fifo_ctrl`

## Requirements
- R1: After reset the entry count is 0, the trigger status is 0, the pop data output is 0, the mode is bypass (code 00) and the threshold is 0, so the watermark flag reads 1.
- R2: A cycle with cfgWrite high loads the mode, select and threshold fields, empties the buffer, sets the count to 0 and clears the trigger status. A sample or a pop offered in that same cycle is ignored.
- R3: In bypass mode (code 00) no sample is stored and the count stays 0.
- R4: In FIFO mode (code 01) samples are stored in arrival order while fewer than 32 entries remain after any same-cycle pop. Samples offered to a full buffer are dropped.
- R5: In stream mode (code 11 is trigger, code 10 is stream) a sample offered to a full buffer is stored and the oldest entry is discarded, so the buffer always holds the newest 32 samples.
- R6: In trigger mode (code 11), before the trigger, the buffer holds at most the last N samples, where N is the threshold. When N is 0 nothing is kept before the trigger.
- R7: In trigger mode, intSrc[0] fires the trigger when cfgTrigSel is 0 and intSrc[1] fires it when cfgTrigSel is 1. The other line has no effect. The trigger status stays set until the next configuration write. In other modes the interrupt lines have no effect.
- R8: After the trigger, samples are stored while the buffer is not full and dropped when it is full. No entry is discarded.
- R9: The watermark flag is 1 when the threshold is 0. Otherwise it is 1 only in FIFO or stream mode with the count at or above the threshold.
- R10: A pop on a non-empty buffer presents the oldest entry on popData in the next cycle and lowers the count by one. A pop on an empty buffer leaves popData and the count unchanged.
- R11: A pop and a sample in the same cycle are both carried out. The pop frees its slot before the fill policy is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | Write strobe for the control fields (flushes the buffer) |
| cfgMode | input | 2 | Fill policy: 00 bypass, 01 FIFO, 10 stream, 11 trigger |
| cfgTrigSel | input | 1 | Trigger source select: 0 picks intSrc[0], 1 picks intSrc[1] |
| cfgSamples | input | 5 | Sample threshold / pre-trigger window size |
| sampleValid | input | 1 | A new sample is offered this cycle |
| sampleData | input | 48 | Three 16-bit axis words |
| popReq | input | 1 | Remove the oldest entry |
| intSrc | input | 2 | Two interrupt lines usable as trigger |
| popData | output | 48 | Entry removed by the latest successful pop |
| entryCount | output | 6 | Number of stored entries (0 to 32) |
| watermark | output | 1 | Threshold reached, or threshold is zero |
| trigSeen | output | 1 | Trigger event latched |

## Verification
Each mode gets a long run of samples that overfills the buffer, and the drain that follows shows which entries were kept. FIFO mode must return the first 32 samples, stream mode the last 32, and trigger mode the pre-trigger window followed by the post-trigger fill. Trigger runs pulse the unselected line first, pulse again after the latch, and also use a zero window, so that select, stickiness and the empty-window case are each tested. Mixed push and pop traffic, pops on an empty buffer, and configuration writes that coincide with samples and pops test slot accounting, hold-last behaviour and flush priority. The watermark is compared every cycle while the count crosses several thresholds, including zero.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_FIFO   = 2'b01,
    MODE_STREAM = 2'b10,
    MODE_TRIG   = 2'b11
  } sfcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;  // reset pointers
    logic push;   // write incoming sample
    logic pop;    // read oldest entry to output
    logic drop;   // discard oldest entry silently
  } sfcStrobe_t;
endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int SMP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgMode,
  input  logic             cfgTrigSel,
  input  logic [SMP_W-1:0] cfgSamples,
  input  logic             sampleValid,
  input  logic             popReq,
  input  logic [1:0]       intSrc,
  output sfcStrobe_t       strobe,
  output logic [CNT_W-1:0] entryCount,
  output logic             watermark,
  output logic             trigSeen
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  sfcMode_e         modeQ;
  logic             trigSelQ;
  logic [SMP_W-1:0] samplesQ;
  logic [CNT_W-1:0] countQ;
  logic             trigQ;
  logic [CNT_W-1:0] afterPop;
  logic [CNT_W-1:0] window;
  logic             popOk, pushOk, dropOk, trigHit;

  assign window = CNT_W'(samplesQ);

  always_comb begin
    popOk    = popReq && (countQ != '0);
    afterPop = countQ - CNT_W'(popOk);
    pushOk   = 1'b0;
    dropOk   = 1'b0;
    if (sampleValid) begin
      unique case (modeQ)
        MODE_BYPASS: pushOk = 1'b0;
        MODE_FIFO:   pushOk = (afterPop < FULL);
        MODE_STREAM: begin
          pushOk = 1'b1;
          dropOk = (afterPop == FULL);
        end
        MODE_TRIG: begin
          if (trigQ) begin
            pushOk = (afterPop < FULL);
          end else if (samplesQ != '0) begin
            pushOk = 1'b1;
            dropOk = (afterPop >= window);
          end
        end
        default: pushOk = 1'b0;
      endcase
    end
    strobe.flush = cfgWrite;
    strobe.pop   = popOk  && !cfgWrite;
    strobe.push  = pushOk && !cfgWrite;
    strobe.drop  = dropOk && !cfgWrite;
  end

  assign trigHit = (modeQ == MODE_TRIG) && !trigQ && intSrc[trigSelQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_BYPASS;
      trigSelQ <= 1'b0;
      samplesQ <= '0;
      countQ   <= '0;
      trigQ    <= 1'b0;
    end else if (cfgWrite) begin
      modeQ    <= sfcMode_e'(cfgMode);
      trigSelQ <= cfgTrigSel;
      samplesQ <= cfgSamples;
      countQ   <= '0;
      trigQ    <= 1'b0;
    end else begin
      countQ <= countQ + CNT_W'(strobe.push) - CNT_W'(strobe.pop) - CNT_W'(strobe.drop);
      if (trigHit) trigQ <= 1'b1;
    end
  end

  assign entryCount = countQ;
  assign trigSeen   = trigQ;
  assign watermark  = (samplesQ == '0) ||
                      (((modeQ == MODE_FIFO) || (modeQ == MODE_STREAM)) && (countQ >= window));

  // R4/R5/R8: never above depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN) countQ <= FULL);
  // R3: bypass keeps nothing
  p_bypass_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_BYPASS) |-> (countQ == '0));
  // R2: a write flushes count and trigger
  p_flush_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (countQ == '0) && !trigQ);
  // R7: trigger stays latched until a config write
  p_trig_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ && !cfgWrite) |=> trigQ);
  // R6: pre-trigger window bounded by threshold
  p_pretrig_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_TRIG) && !trigQ) |-> (countQ <= window));
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 48,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sfcStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [SAMPLE_W-1:0] popData
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      popData <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop) begin
        popData <= mem[rdPtr];
        rdPtr   <= bump(rdPtr);
      end else if (strobe.drop) begin
        rdPtr <= bump(rdPtr);
      end
    end
  end

  // R11: pop and discard never both advance the read side
  p_pop_drop_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.pop && strobe.drop));
  // R10: data output only moves on a pop
  p_popdata_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pop |=> $stable(popData));
endmodule

// File: rtl/sample_fifo_ctrl.sv
module sample_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int AXIS_W   = 16,
  parameter int SAMPLE_W = 3 * AXIS_W,
  parameter int CNT_W    = $clog2(DEPTH + 1),
  parameter int SMP_W    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrite,
  input  logic [1:0]          cfgMode,
  input  logic                cfgTrigSel,
  input  logic [SMP_W-1:0]    cfgSamples,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                popReq,
  input  logic [1:0]          intSrc,
  output logic [SAMPLE_W-1:0] popData,
  output logic [CNT_W-1:0]    entryCount,
  output logic                watermark,
  output logic                trigSeen
);
  sfcStrobe_t strobe;

  sfc_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .SMP_W(SMP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgMode(cfgMode),
    .cfgTrigSel(cfgTrigSel), .cfgSamples(cfgSamples), .sampleValid(sampleValid),
    .popReq(popReq), .intSrc(intSrc), .strobe(strobe), .entryCount(entryCount),
    .watermark(watermark), .trigSeen(trigSeen)
  );

  sfc_datapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .popData(popData)
  );
endmodule

// File: tb/sample_fifo_ctrl_test.sv
module sample_fifo_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgMode = 2'b00;
  logic        cfgTrigSel = 1'b0;
  logic [4:0]  cfgSamples = 5'd0;
  logic        sampleValid = 1'b0;
  logic [47:0] sampleData = '0;
  logic        popReq = 1'b0;
  logic [1:0]  intSrc = 2'b00;
  logic [47:0] popData;
  logic [5:0]  entryCount;
  logic        watermark, trigSeen;

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  bit checking = 0;
  bit done = 0;
  logic [47:0] seq = 48'h1000_2000_3000;

  // reference model state
  logic [47:0] q[$];
  logic [47:0] mPop = '0;
  int mMode = 0, mN = 0, mSel = 0;
  bit mTrig = 0;

  sample_fifo_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgMode(cfgMode),
    .cfgTrigSel(cfgTrigSel), .cfgSamples(cfgSamples), .sampleValid(sampleValid),
    .sampleData(sampleData), .popReq(popReq), .intSrc(intSrc), .popData(popData),
    .entryCount(entryCount), .watermark(watermark), .trigSeen(trigSeen)
  );

  always #5 clk = ~clk;

  function automatic bit expWm();
    if (mN == 0) return 1'b1;
    return ((mMode == 1) || (mMode == 2)) && (q.size() >= mN);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mPop = '0; mMode = 0; mN = 0; mSel = 0; mTrig = 0;
    end else if (cfgWrite) begin
      mMode = int'(cfgMode); mN = int'(cfgSamples); mSel = int'(cfgTrigSel);
      q.delete(); mTrig = 0;
    end else begin
      if (popReq && q.size() > 0) mPop = q.pop_front();
      if (sampleValid) begin
        case (mMode)
          1: if (q.size() < 32) q.push_back(sampleData);
          2: begin
            if (q.size() == 32) void'(q.pop_front());
            q.push_back(sampleData);
          end
          3: begin
            if (mTrig) begin
              if (q.size() < 32) q.push_back(sampleData);
            end else if (mN != 0) begin
              if (q.size() >= mN) void'(q.pop_front());
              q.push_back(sampleData);
            end
          end
          default: ;
        endcase
      end
      if (mMode == 3 && !mTrig && intSrc[mSel]) mTrig = 1;
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(phase, "entryCount", longint'(entryCount), longint'(q.size()));
      check(phase, "watermark", longint'(watermark), longint'(expWm()));
      check(phase, "trigSeen", longint'(trigSeen), longint'(mTrig));
      check(phase, "popData", longint'(popData), longint'(mPop));
    end
  end

  task automatic cyc(input bit v, input bit p, input logic [1:0] src);
    sampleValid = v;
    sampleData  = seq;
    if (v) seq = seq + 48'h0001_0003_0007;
    popReq = p;
    intSrc = src;
    @(negedge clk);
    sampleValid = 0; popReq = 0; intSrc = 2'b00;
  endtask

  // R2: write with a sample and a pop offered in the same cycle
  task automatic cfg(input logic [1:0] m, input bit sel, input logic [4:0] n);
    cfgWrite = 1; cfgMode = m; cfgTrigSel = sel; cfgSamples = n;
    sampleValid = 1; sampleData = seq; popReq = 1;
    @(negedge clk);
    cfgWrite = 0; sampleValid = 0; popReq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "count", longint'(entryCount), 0);
    check("R1", "trigSeen", longint'(trigSeen), 0);
    check("R1", "popData", longint'(popData), 0);
    check("R1", "watermark", longint'(watermark), 1);
    rstN = 1;
    @(negedge clk);
    checking = 1;

    phase = "R3"; cfg(2'b00, 0, 5'd4);
    for (int i = 0; i < 6; i++) cyc(1, 0, 2'b11);
    cyc(0, 1, 2'b00);

    phase = "R4"; cfg(2'b01, 0, 5'd8);
    for (int i = 0; i < 40; i++) cyc(1, 0, 2'b01);
    phase = "R10";
    for (int i = 0; i < 34; i++) cyc(0, 1, 2'b00);

    phase = "R9"; cfg(2'b01, 0, 5'd3);
    for (int i = 0; i < 5; i++) cyc(1, 0, 2'b00);
    for (int i = 0; i < 3; i++) cyc(0, 1, 2'b00);
    cfg(2'b10, 0, 5'd0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 2'b00);

    phase = "R5"; cfg(2'b10, 0, 5'd31);
    for (int i = 0; i < 45; i++) cyc(1, 0, 2'b00);
    phase = "R11";
    for (int i = 0; i < 6; i++) cyc(1, 1, 2'b00);
    for (int i = 0; i < 35; i++) cyc(0, 1, 2'b00);

    phase = "R6"; cfg(2'b11, 1, 5'd5);
    for (int i = 0; i < 12; i++) cyc(1, 0, 2'b00);
    phase = "R7";
    cyc(1, 0, 2'b01);
    cyc(1, 0, 2'b00);
    cyc(1, 0, 2'b10);
    phase = "R8";
    for (int i = 0; i < 40; i++) cyc(1, 0, (i == 10) ? 2'b10 : 2'b00);
    for (int i = 0; i < 34; i++) cyc(0, 1, 2'b00);

    phase = "R6"; cfg(2'b11, 0, 5'd0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 2'b10);
    phase = "R7"; cyc(1, 0, 2'b01);
    for (int i = 0; i < 5; i++) cyc(1, 0, 2'b00);

    phase = "R11"; cfg(2'b01, 0, 5'd4);
    for (int i = 0; i < 60; i++) cyc((i % 3) != 2, (i % 2) == 0, 2'b00);
    for (int i = 0; i < 33; i++) cyc(1, 0, 2'b00);
    for (int i = 0; i < 4; i++) cyc(1, 1, 2'b00);

    phase = "R2"; cfg(2'b10, 0, 5'd2);
    cyc(1, 0, 2'b00);
    cfg(2'b01, 0, 5'd2);
    cyc(0, 1, 2'b00);

    checking = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule